// File: doc/BRIEF.md
# Control Port Register Interface

This block is the 64-location management port of a switching chip. An external
network controller drives a 6-bit address, an 8-bit write byte, an active-low
write strobe and an active-low output enable. All of these are sampled in the
chip clock domain. The block keeps the chip's configuration bytes and turns
writes to command locations into timed pulses. It also returns a byte from the
configuration, status or statistics sources whenever the controller asks for a
read.

A write is started by a falling edge on the synchronized write strobe. At that
point the block captures three things: the write byte, the low three address
bits, and a flag that records whether the top three address bits are zero. The
captured write then becomes at most one single-cycle enable out of eight. Five
locations are read/write bytes. Three are write-only command triggers. Status
bytes and statistics words arrive on plain input buses. Statistics are returned
one byte at a time, and the address picks the word and the byte.

Top module: `ctlport_top`

## Requirements
- R1: After reset, every configuration byte reads as zero, no command pulse is active, `cp_rdata` is 0x00 and `cp_rdrive` is low.
- R2: A write to location 0 to 4 stores the write byte. The byte at location k appears on `cfg_values[8k+7:8k]` and is returned by a read of location k.
- R3: A write to any location at or above 8 changes no configuration byte and fires no command pulse.
- R4: Address and data are captured at the detected strobe edge. Changes to those inputs later in the same strobe do not alter the write.
- R5: Each assertion of the write strobe produces exactly one write, however long the strobe is held low.
- R6: A write to location 5 produces a pulse on `clr_err_pulse` that is exactly 1 clock cycle long.
- R7: A write to location 6 produces a pulse on `reset_cmd_pulse` that is exactly 6 cycles long. A write to location 7 produces a pulse on `sync_cmd_pulse` that is exactly 6 cycles long.
- R8: Reads of locations 5, 6 and 7 return 0x00.
- R9: A read of location 8+j (j = 0..7) returns `status_bytes[8j+7:8j]`.
- R10: A read of an address of 16 or more returns one byte of statistics word i = addr[3:0], where word i is `stats_words[24i+23:24i]`. addr[5:4] = 1, 2 and 3 select bits 7:0, 15:8 and 23:16 respectively.
- R11: `cp_rdrive` is high in the cycle after a clock edge that samples `cp_oe_n` low. `cp_rdata` holds the addressed byte only then and is 0x00 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_addr | input | 6 | Location address |
| cp_wdata | input | 8 | Byte to write |
| cp_wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| cp_oe_n | input | 1 | Active-low read output enable |
| cp_rdata | output | 8 | Read byte, zero when not driving |
| cp_rdrive | output | 1 | High when cp_rdata carries read data |
| status_bytes | input | 64 | Eight status bytes, byte j at bits 8j+7:8j |
| stats_words | input | 384 | Sixteen 24-bit statistics words |
| cfg_values | output | 40 | The five stored configuration bytes |
| clr_err_pulse | output | 1 | Error-counter clear command pulse |
| reset_cmd_pulse | output | 1 | Reset command pulse |
| sync_cmd_pulse | output | 1 | Link synchronize command pulse |

## Verification
The bench holds the strobe low for many cycles against the clear location. A design that edge-detected badly would issue repeated writes, and the clear pulse would then last longer than one cycle. It also changes the address and data while the strobe is still low. If capture were not in place, the wrong location or value would be written. It writes to high addresses whose low three bits match live registers, and an address decode that ignored the upper bits would corrupt those registers. Reads sweep all three statistics byte lanes, the status bytes and the write-only locations, so a wrong lane order or a byte leaked from a write-only location shows up as a data mismatch.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
    localparam int AW       = 6;
    localparam int DW       = 8;
    localparam int NLOC     = 8;
    localparam int NUM_RW   = 5;
    localparam int NUM_CMD  = NLOC - NUM_RW;
    localparam int NSTAT    = 8;
    localparam int STAT_N   = 16;
    localparam int STAT_W   = 24;
    localparam int IDX_W    = $clog2(NLOC);

    typedef struct packed {
        logic             valid;
        logic             low_page;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
    } wr_cap_t;
endpackage

// File: rtl/ctlport_wrcap.sv
module ctlport_wrcap
    import ctlport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic                wr_n_i,
    output logic [NLOC-1:0]     we_o,
    output logic [DW-1:0]       wbyte_o
);
    localparam int HI_W = AW - IDX_W;

    typedef struct packed {
        logic    sync1;
        logic    sync2;
        logic    sync3;
        wr_cap_t cap;
    } wst_t;

    wst_t st_d, st_q;
    logic fall;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = wr_n_i;
        st_d.sync2 = st_q.sync1;
        st_d.sync3 = st_q.sync2;
        fall       = st_q.sync3 & ~st_q.sync2;
        st_d.cap.valid = fall;
        if (fall) begin
            st_d.cap.idx      = addr_i[IDX_W-1:0];
            st_d.cap.low_page = (addr_i[AW-1 -: HI_W] == '0);
            st_d.cap.data     = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync1 <= 1'b1;
            st_q.sync2 <= 1'b1;
            st_q.sync3 <= 1'b1;
            st_q.cap   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        we_o = '0;
        if (st_q.cap.valid && st_q.cap.low_page)
            we_o[st_q.cap.idx] = 1'b1;
    end
    assign wbyte_o = st_q.cap.data;

    assert_we_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_o));
    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o != '0) |=> (we_o == '0));
    assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(st_q.cap.data));
endmodule

// File: rtl/ctlport_regs.sv
module ctlport_regs
    import ctlport_pkg::*;
#(
    parameter int CLR_LEN = 1,
    parameter int CMD_LEN = 6
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLOC-1:0]        we_i,
    input  logic [DW-1:0]          wbyte_i,
    output logic [NUM_RW*DW-1:0]   cfg_o,
    output logic [NUM_CMD-1:0]     cmd_o
);
    localparam int MAXLEN = (CLR_LEN > CMD_LEN) ? CLR_LEN : CMD_LEN;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    typedef struct packed {
        logic [NUM_RW-1:0][DW-1:0]     cfg;
        logic [NUM_CMD-1:0][CNT_W-1:0] cnt;
    } rst_t;

    rst_t st_d, st_q;

    function automatic logic [CNT_W-1:0] cmd_len(input int j);
        return (j == 0) ? CNT_W'(CLR_LEN) : CNT_W'(CMD_LEN);
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_RW; i++)
            if (we_i[i]) st_d.cfg[i] = wbyte_i;
        for (int j = 0; j < NUM_CMD; j++) begin
            if (we_i[NUM_RW + j])
                st_d.cnt[j] = cmd_len(j);
            else if (st_q.cnt[j] != '0)
                st_d.cnt[j] = st_q.cnt[j] - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    for (genvar j = 0; j < NUM_CMD; j++) begin : g_cmd
        assign cmd_o[j] = (st_q.cnt[j] != '0);
        assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[j] <= cmd_len(j));
    end

    assert_cfg_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i[NUM_RW-1:0] == '0) |=> $stable(cfg_o));
    assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[0] && !we_i[NUM_RW]) |=> !cmd_o[0]);
endmodule

// File: rtl/ctlport_rdmux.sv
module ctlport_rdmux
    import ctlport_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr_i,
    input  logic                       oe_n_i,
    input  logic [NUM_RW*DW-1:0]       cfg_i,
    input  logic [NSTAT*DW-1:0]        status_i,
    input  logic [STAT_N*STAT_W-1:0]   stats_i,
    output logic [DW-1:0]              rdata_o,
    output logic                       rdrive_o
);
    typedef struct packed {
        logic          drive;
        logic [DW-1:0] data;
    } rd_t;

    rd_t st_d, st_q;
    logic [DW-1:0]     sel;
    logic [STAT_W-1:0] word;
    logic [IDX_W-1:0]  lo;

    always_comb begin
        lo   = addr_i[IDX_W-1:0];
        word = stats_i[addr_i[3:0]*STAT_W +: STAT_W];
        sel  = '0;
        case (addr_i[5:4])
            2'd0: begin
                if (addr_i[3])
                    sel = status_i[lo*DW +: DW];
                else if (int'(lo) < NUM_RW)
                    sel = cfg_i[lo*DW +: DW];
            end
            2'd1: sel = word[7:0];
            2'd2: sel = word[15:8];
            default: sel = word[23:16];
        endcase
        st_d.drive = ~oe_n_i;
        st_d.data  = oe_n_i ? '0 : sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o  = st_q.data;
    assign rdrive_o = st_q.drive;

    assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdrive_o |-> (rdata_o == '0));
    assert_drive_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_i |=> rdrive_o);
endmodule

// File: rtl/ctlport_top.sv
module ctlport_top
    import ctlport_pkg::*;
#(
    parameter int CLR_LEN = 1,
    parameter int CMD_LEN = 6
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             cp_addr,
    input  logic [DW-1:0]             cp_wdata,
    input  logic                      cp_wr_n,
    input  logic                      cp_oe_n,
    output logic [DW-1:0]             cp_rdata,
    output logic                      cp_rdrive,
    input  logic [NSTAT*DW-1:0]       status_bytes,
    input  logic [STAT_N*STAT_W-1:0]  stats_words,
    output logic [NUM_RW*DW-1:0]      cfg_values,
    output logic                      clr_err_pulse,
    output logic                      reset_cmd_pulse,
    output logic                      sync_cmd_pulse
);
    logic [NLOC-1:0]    we;
    logic [DW-1:0]      wbyte;
    logic [NUM_CMD-1:0] cmd;

    ctlport_wrcap u_wrcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (cp_addr),
        .wdata_i (cp_wdata),
        .wr_n_i  (cp_wr_n),
        .we_o    (we),
        .wbyte_o (wbyte)
    );

    ctlport_regs #(.CLR_LEN(CLR_LEN), .CMD_LEN(CMD_LEN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .wbyte_i (wbyte),
        .cfg_o   (cfg_values),
        .cmd_o   (cmd)
    );

    ctlport_rdmux u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (cp_addr),
        .oe_n_i   (cp_oe_n),
        .cfg_i    (cfg_values),
        .status_i (status_bytes),
        .stats_i  (stats_words),
        .rdata_o  (cp_rdata),
        .rdrive_o (cp_rdrive)
    );

    assign clr_err_pulse   = cmd[0];
    assign reset_cmd_pulse = cmd[1];
    assign sync_cmd_pulse  = cmd[2];

    assert_cmd_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_err_pulse) |-> $past(we[NUM_RW]));
endmodule

// File: tb/ctlport_top_bench.sv
module ctlport_top_bench;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [5:0]   cp_addr = '0;
    logic [7:0]   cp_wdata = '0;
    logic         cp_wr_n = 1;
    logic         cp_oe_n = 1;
    logic [7:0]   cp_rdata;
    logic         cp_rdrive;
    logic [63:0]  status_bytes;
    logic [383:0] stats_words;
    logic [39:0]  cfg_values;
    logic         clr_err_pulse, reset_cmd_pulse, sync_cmd_pulse;

    int checks = 0, errors = 0;
    logic [7:0] model [5];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    int n_clr = 0, n_rst = 0, n_syn = 0;

    always #4 clk = ~clk;

    ctlport_top u_ctlport_top (
        .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_wr_n(cp_wr_n), .cp_oe_n(cp_oe_n), .cp_rdata(cp_rdata),
        .cp_rdrive(cp_rdrive), .status_bytes(status_bytes),
        .stats_words(stats_words), .cfg_values(cfg_values),
        .clr_err_pulse(clr_err_pulse), .reset_cmd_pulse(reset_cmd_pulse),
        .sync_cmd_pulse(sync_cmd_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [5:0] a);
        logic [23:0] w;
        w = stats_words[a[3:0]*24 +: 24];
        case (a[5:4])
            2'd0: exp_read = a[3] ? status_bytes[a[2:0]*8 +: 8]
                                  : (a[2:0] < 5 ? model[a[2:0]] : 8'h00);
            2'd1: exp_read = w[7:0];
            2'd2: exp_read = w[15:8];
            default: exp_read = w[23:16];
        endcase
    endfunction

    // Monitor: count pulse widths and score read data.
    always @(negedge clk) begin
        if (rst_n) begin
            if (clr_err_pulse)   n_clr++;
            if (reset_cmd_pulse) n_rst++;
            if (sync_cmd_pulse)  n_syn++;
            if (cp_rdrive) begin
                if (exp_q.size() == 0) check("R11 unexpected drive", 1, 0);
                else check(tag_q.pop_front(), cp_rdata, exp_q.pop_front());
            end else begin
                check("R11 idle bus", cp_rdata, 0);
            end
        end
    end

    task automatic do_read(input logic [5:0] a, input string req);
        @(negedge clk);
        cp_addr = a;
        cp_oe_n = 0;
        exp_q.push_back(exp_read(a));
        tag_q.push_back(req);
        @(negedge clk);
        cp_oe_n = 1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        cp_addr = a; cp_wdata = d; cp_wr_n = 0;
        repeat (hold) @(negedge clk);
        cp_wr_n = 1;
        repeat (8) @(negedge clk);
        if (a < 5) model[a[2:0]] = d;
    endtask

    task automatic clear_counts();
        n_clr = 0; n_rst = 0; n_syn = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) status_bytes[i*8 +: 8] = 8'hA0 + 8'(i);
        for (int i = 0; i < 16; i++) stats_words[i*24 +: 24] = 24'h0A0B0C + 24'(i) * 24'h010203;
        for (int i = 0; i < 5; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg", cfg_values, 0);
        check("R1 pulses", {clr_err_pulse, reset_cmd_pulse, sync_cmd_pulse}, 0);
        check("R1 rdrive", cp_rdrive, 0);
        do_read(6'd2, "R1 readback zero");

        // R2 plain writes and readback
        for (int k = 0; k < 5; k++) do_write(6'(k), 8'h31 + 8'(k * 17), 3);
        for (int k = 0; k < 5; k++) begin
            check("R2 cfg port", cfg_values[k*8 +: 8], model[k]);
            do_read(6'(k), "R2 readback");
        end

        // R3 high addresses aliasing live registers
        clear_counts();
        do_write(6'd10, 8'hEE, 3);
        do_write(6'd42, 8'hDD, 3);
        do_write(6'd63, 8'hCC, 3);
        do_write(6'd13, 8'hBB, 3);
        check("R3 cfg unchanged", cfg_values, {model[4], model[3], model[2], model[1], model[0]});
        check("R3 no pulses", n_clr + n_rst + n_syn, 0);

        // R4 inputs change while strobe still low
        @(negedge clk);
        cp_addr = 6'd1; cp_wdata = 8'h5A; cp_wr_n = 0;
        repeat (5) @(negedge clk);
        cp_addr = 6'd3; cp_wdata = 8'hC3;
        repeat (3) @(negedge clk);
        cp_wr_n = 1;
        repeat (8) @(negedge clk);
        model[1] = 8'h5A;
        check("R4 captured target", cfg_values[15:8], 8'h5A);
        check("R4 other untouched", cfg_values[31:24], model[3]);

        // R5 + R6 long strobe to clear location
        clear_counts();
        do_write(6'd5, 8'hFF, 25);
        repeat (10) @(negedge clk);
        check("R5 R6 clear width", n_clr, 1);
        check("R6 no other cmd", n_rst + n_syn, 0);

        // R7 reset and sync widths
        clear_counts();
        do_write(6'd6, 8'h01, 3);
        repeat (10) @(negedge clk);
        check("R7 reset width", n_rst, 6);
        clear_counts();
        do_write(6'd7, 8'h01, 12);
        repeat (10) @(negedge clk);
        check("R7 sync width", n_syn, 6);
        check("R7 cfg unchanged", cfg_values, {model[4], model[3], model[2], model[1], model[0]});

        // R8 write-only locations read zero
        for (int k = 5; k < 8; k++) do_read(6'(k), "R8 write-only read");

        // R9 status bytes
        for (int j = 0; j < 8; j++) do_read(6'(8 + j), "R9 status");

        // R10 statistics lanes
        do_read(6'd16, "R10 word0 lane0");
        do_read(6'd37, "R10 word5 lane1");
        do_read(6'd63, "R10 word15 lane2");
        do_read(6'd58, "R10 word10 lane2");
        do_read(6'd25, "R10 word9 lane0");

        // R11 queue drained, bus idle
        repeat (4) @(negedge clk);
        check("R11 all reads seen", exp_q.size(), 0);
        check("R11 drive low", cp_rdrive, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule